// File: doc/BRIEF.md
# Pointer-Recoverable Register Rename Map

This block holds the speculative register map of a four-wide rename stage. Every architectural register has its own small ring of physical tags. The entry that the ring's tail pointer selects is the register's current mapping. When instructions in a rename group name a register as their destination, their new physical tags are placed in that register's ring, in the slots just past the tail. The tail then moves forward so that it selects the youngest of those tags. Source operands are looked up by reading the tail entry of the named ring.

Each ring keeps older mappings until it wraps around and overwrites them. A separate checkpoint unit can therefore save the block's tail pointers when a branch is renamed. On a misprediction it loads them back, and the map returns to its earlier state in a single cycle without copying any map. Dependencies between instructions of one group, the freeing of physical registers and commit are all handled outside this block.

Top module: `rn_ring_map`

## Requirements
- R1: After synchronous reset every tail pointer is 0 and every entry of ring r holds tag r, so a lookup of register r returns r.
- R2: Each of the 8 lookup ports returns, combinationally, the tag at the current tail of the named register's ring. Renames presented in the same cycle become visible only after the next rising clock edge.
- R3: One valid rename lane for register r writes its tag at slot tail+1 of ring r, and the tail advances by one.
- R4: When k valid lanes name the same register, they write slots tail+1 to tail+k in lane order, with lane 0 taken as oldest. The tail advances by k, and the next lookup returns the tag of the highest-numbered of those lanes.
- R5: A lane whose valid bit is low changes no ring and no tail, whatever its register and tag fields hold.
- R6: When restore is high, every tail is loaded from the restore vector on that edge, and all rename lanes of that cycle are dropped. A lookup afterwards returns the tag stored at the restored slot.
- R7: Tail arithmetic is modulo 16, so a tail at 15 that advances by n moves to n-1.
- R8: The tail of register r appears on the output vector at bits [4r+3:4r]. The restore input uses the same layout.
- R9: In a cycle with no valid lanes and no restore, every mapping and every tail stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 4 | Per-lane rename enable |
| ren_areg | input | 4x3 | Per-lane destination architectural register |
| ren_ptag | input | 4x6 | Per-lane new physical tag |
| src_areg | input | 8x3 | Architectural register named by each lookup port |
| src_ptag | output | 8x6 | Current physical tag for each lookup port |
| restore_en | input | 1 | Load all tails from restore_ptrs; overrides renames |
| restore_ptrs | input | 32 | Tail vector to restore, 4 bits per register |
| tail_ptrs | output | 32 | Current tail vector, 4 bits per register |

## Verification
The assertions check four things on every cycle: that a ring's tail moves by exactly the number of lanes that hit it, that the youngest tag written becomes the head mapping, that an idle ring keeps its head, and that a restore appears on the tail output one edge later. Only the bench's scenarios can show the rest. These are the ordering of slots between lanes that share a destination, wrap-around across many groups, recovery of an older mapping after later renames, and the fact that same-cycle renames stay invisible to lookups. The bench shows them by comparing every lookup and every tail against an arithmetic model over directed and pseudo-random groups.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int NUM_AREGS = 8;
    localparam int TAG_W     = 6;
    localparam int DEPTH     = 16;
    localparam int LANES     = 4;
    localparam int NUM_SRC   = 8;
    localparam int AREG_W    = $clog2(NUM_AREGS);
    localparam int PTR_W     = $clog2(DEPTH);
    localparam int VEC_W     = NUM_AREGS * PTR_W;

    typedef logic [TAG_W-1:0]  ptag_t;
    typedef logic [AREG_W-1:0] areg_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef struct packed {
        logic  valid;
        areg_t areg;
        ptag_t ptag;
    } ren_req_t;

    typedef struct packed {
        logic [LANES-1:0]            hit;
        logic [LANES-1:0][PTR_W-1:0] ofs;
        ptr_t                        cnt;
    } ring_wr_t;

    function automatic ptr_t ring_add(input ptr_t base, input ptr_t step);
        return ptr_t'(base + step);
    endfunction
endpackage

// File: rtl/rn_lane_decode.sv
module rn_lane_decode
    import rn_pkg::*;
#(
    parameter int QIDX = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  ren_req_t [LANES-1:0] req,
    output ring_wr_t            wr
);
    always_comb begin
        ptr_t acc;
        acc = '0;
        wr  = '0;
        for (int l = 0; l < LANES; l++) begin
            if (req[l].valid && req[l].areg == areg_t'(QIDX)) begin
                acc       = ptr_t'(acc + 1'b1);
                wr.hit[l] = 1'b1;
                wr.ofs[l] = acc;
            end
        end
        wr.cnt = acc;
    end

    // R4: the slot count handed to the ring matches the lanes that hit it
    a_r4_hit_count: assert property (@(posedge clk) disable iff (rst)
        ($countones(wr.hit) == int'(wr.cnt)));

    // R5: a lane without valid never produces a write
    a_r5_invalid_quiet: assert property (@(posedge clk) disable iff (rst)
        ((wr.hit & ~{req[3].valid, req[2].valid, req[1].valid, req[0].valid}) == '0));
endmodule

// File: rtl/rn_map_ring.sv
module rn_map_ring
    import rn_pkg::*;
#(
    parameter int QIDX = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  ring_wr_t            wr,
    input  ren_req_t [LANES-1:0] req,
    input  logic                restore_en,
    input  ptr_t                restore_ptr,
    output ptr_t                tail,
    output ptag_t               head_tag
);
    ptag_t slots [DEPTH];
    ptag_t young_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            tail <= '0;
            for (int e = 0; e < DEPTH; e++) slots[e] <= ptag_t'(QIDX);
        end else if (restore_en) begin
            tail <= restore_ptr;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (wr.hit[l]) slots[ring_add(tail, ptr_t'(wr.ofs[l]))] <= req[l].ptag;
            end
            tail <= ring_add(tail, wr.cnt);
        end
    end

    assign head_tag = slots[tail];

    always_comb begin
        young_tag = '0;
        for (int l = 0; l < LANES; l++) begin
            if (wr.hit[l]) young_tag = req[l].ptag;
        end
    end

    // R3 / R7: tail moves by the write count, modulo ring depth
    a_r7_tail_advance: assert property (@(posedge clk) disable iff (rst)
        (!restore_en) |=> (tail == ptr_t'($past(tail) + $past(wr.cnt))));

    // R4: the youngest tag of a group becomes the head mapping
    a_r4_youngest_head: assert property (@(posedge clk) disable iff (rst)
        (!restore_en && wr.cnt != '0) |=> (head_tag == $past(young_tag)));

    // R9: an idle ring keeps its mapping
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!restore_en && wr.cnt == '0) |=> ($stable(head_tag) && $stable(tail)));
endmodule

// File: rtl/rn_src_read.sv
module rn_src_read
    import rn_pkg::*;
(
    input  ptag_t [NUM_AREGS-1:0] head_tags,
    input  areg_t [NUM_SRC-1:0]   src_areg,
    output ptag_t [NUM_SRC-1:0]   src_ptag
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_port
        assign src_ptag[s] = head_tags[src_areg[s]];
    end
endmodule

// File: rtl/rn_ring_map.sv
module rn_ring_map
    import rn_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic [LANES-1:0]                   ren_valid,
    input  logic [LANES-1:0][AREG_W-1:0]       ren_areg,
    input  logic [LANES-1:0][TAG_W-1:0]        ren_ptag,
    input  logic [NUM_SRC-1:0][AREG_W-1:0]     src_areg,
    output logic [NUM_SRC-1:0][TAG_W-1:0]      src_ptag,
    input  logic                               restore_en,
    input  logic [VEC_W-1:0]                   restore_ptrs,
    output logic [VEC_W-1:0]                   tail_ptrs
);
    ren_req_t [LANES-1:0]     req;
    ptag_t [NUM_AREGS-1:0]    head_tags;
    areg_t [NUM_SRC-1:0]      src_sel;
    ptag_t [NUM_SRC-1:0]      src_out;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign req[l] = '{valid: ren_valid[l], areg: ren_areg[l], ptag: ren_ptag[l]};
    end

    for (genvar q = 0; q < NUM_AREGS; q++) begin : g_ring
        ring_wr_t wr;
        ptr_t     tail;

        rn_lane_decode #(.QIDX(q)) dec_i (
            .clk (clk),
            .rst (rst),
            .req (req),
            .wr  (wr)
        );

        rn_map_ring #(.QIDX(q)) ring_i (
            .clk         (clk),
            .rst         (rst),
            .wr          (wr),
            .req         (req),
            .restore_en  (restore_en),
            .restore_ptr (restore_ptrs[q*PTR_W +: PTR_W]),
            .tail        (tail),
            .head_tag    (head_tags[q])
        );

        assign tail_ptrs[q*PTR_W +: PTR_W] = tail;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign src_sel[s]  = src_areg[s];
        assign src_ptag[s] = src_out[s];
    end

    rn_src_read rd_i (
        .head_tags (head_tags),
        .src_areg  (src_sel),
        .src_ptag  (src_out)
    );

    // R6 / R8: a restore shows up on the tail output after one edge
    a_r6_restore_load: assert property (@(posedge clk) disable iff (rst)
        restore_en |=> (tail_ptrs == $past(restore_ptrs)));
endmodule

// File: tb/rn_ring_map_tb_top.sv
module rn_ring_map_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic [3:0]       v;
    logic [3:0][2:0]  ar;
    logic [3:0][5:0]  pt;
    logic [7:0][2:0]  sa;
    logic [7:0][5:0]  sp;
    logic             rs;
    logic [31:0]      rp;
    logic [31:0]      tp;

    int n_run = 0, n_fail = 0;
    int mtail [8];
    int mmem  [8][16];
    int unsigned seed = 32'h1234_5678;
    logic [31:0] saved;
    bit done = 0;

    always #4 clk = ~clk;

    rn_ring_map dut_i (
        .clk(clk), .rst(rst), .ren_valid(v), .ren_areg(ar), .ren_ptag(pt),
        .src_areg(sa), .src_ptag(sp), .restore_en(rs), .restore_ptrs(rp),
        .tail_ptrs(tp)
    );

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    task automatic model_reset();
        for (int r = 0; r < 8; r++) begin
            mtail[r] = 0;
            for (int e = 0; e < 16; e++) mmem[r][e] = r;
        end
    endtask

    task automatic model_apply();
        int cnt [8];
        for (int r = 0; r < 8; r++) cnt[r] = 0;
        if (rs) begin
            for (int r = 0; r < 8; r++) mtail[r] = int'(rp[r*4 +: 4]);
        end else begin
            for (int l = 0; l < 4; l++) begin
                if (v[l]) begin
                    cnt[ar[l]]++;
                    mmem[ar[l]][(mtail[ar[l]] + cnt[ar[l]]) % 16] = int'(pt[l]);
                end
            end
            for (int r = 0; r < 8; r++) mtail[r] = (mtail[r] + cnt[r]) % 16;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_apply();
        @(negedge clk);
    endtask

    task automatic idle();
        v = '0; ar = '0; pt = '0; rs = 1'b0; rp = '0;
    endtask

    task automatic check_all(input string req, input int rot);
        for (int s = 0; s < 8; s++) sa[s] = 3'((s + rot) % 8);
        #1;
        for (int s = 0; s < 8; s++) begin
            int r = (s + rot) % 8;
            int exp = mmem[r][mtail[r]];
            n_run++;
            if (int'(sp[s]) != exp) begin
                n_fail++;
                $display("FAIL %s lookup port %0d reg %0d: got %0d exp %0d", req, s, r, sp[s], exp);
            end
        end
        for (int r = 0; r < 8; r++) begin
            n_run++;
            if (int'(tp[r*4 +: 4]) != mtail[r]) begin
                n_fail++;
                $display("FAIL %s R8 tail reg %0d: got %0d exp %0d", req, r, tp[r*4 +: 4], mtail[r]);
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        sa = '0;
        rst = 1'b1;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_all("R1", 0);

        // R3: single rename of register 3
        v = 4'b0001; ar[0] = 3'd3; pt[0] = 6'd40;
        step(); idle();
        check_all("R3", 1);

        // R4: four lanes on register 5, lane 3 youngest
        v = 4'b1111;
        for (int l = 0; l < 4; l++) begin ar[l] = 3'd5; pt[l] = 6'(10 + l); end
        step(); idle();
        check_all("R4", 2);

        // R5 / R9: fields set but no valid bits
        ar = {3'd1, 3'd2, 3'd3, 3'd5}; pt = {6'd60, 6'd61, 6'd62, 6'd63};
        step(); idle();
        check_all("R5", 3);
        step();
        check_all("R9", 4);

        // R7: 20 renames of register 0 wrap its tail
        for (int c = 0; c < 5; c++) begin
            v = 4'b1111;
            for (int l = 0; l < 4; l++) begin ar[l] = 3'd0; pt[l] = 6'(20 + 4*c + l); end
            step(); idle();
            check_all("R7", c);
        end

        // R6: save, rename register 2 further, restore with lanes active
        saved = tp;
        for (int c = 0; c < 3; c++) begin
            v = 4'b0011; ar[0] = 3'd2; ar[1] = 3'd2; pt[0] = 6'(50 + c); pt[1] = 6'(55 + c);
            step(); idle();
        end
        check_all("R4", 5);
        rs = 1'b1; rp = saved;
        v = 4'b1111; ar = {3'd2, 3'd3, 3'd4, 3'd2}; pt = {6'd1, 6'd2, 6'd3, 6'd4};
        step(); idle();
        check_all("R6", 6);

        // R2: pseudo-random groups; lookups before edge must show old state
        for (int c = 0; c < 400; c++) begin
            int unsigned x = rnd();
            v  = 4'(x);
            ar = 12'(rnd());
            pt = 24'(rnd());
            rs = (rnd() % 13) == 0;
            rp = rnd();
            check_all("R2", c);
            step(); idle();
            check_all("R2", c + 3);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule